// File: doc/BRIEF.md
# CPU-to-Memory-Controller Handshake Bridge

This block lets a slow 8-bit CPU bus use a faster, word-organized memory controller that needs several clock cycles per access. The CPU presents a request with a 16-bit address, a direction bit and a data byte. The bridge turns that request into a held request on the controller side and stalls the CPU until the controller acknowledges.

The CPU's 64 KB window is extended with a 7-bit bank register, which gives a 23-bit (8 MB) physical byte space. The bank register is loaded by a CPU write to a fixed I/O address. The controller data path is 32 bits wide, so the bridge sends a 21-bit word address and picks one of four byte lanes. On a write it places the byte on every lane and enables only the addressed lane. On a read it captures the returned word and hands the addressed byte back to the CPU.

The controller is a request/acknowledge port. Its request is made of a direction line and two request lines that always move together.

Top module: `cpu_dram_bridge`

## Requirements
- R1: After reset, `cpu_ready` is 1, `mem_strobe`, `mem_cycle` and `mem_write` are 0, and the bank register is 0. The first access after reset therefore uses physical address {7'h00, cpu_addr}.
- R2: A request is accepted when `cpu_req` is 1 at a clock edge while `cpu_ready` is 1 and it is not a bank-register write. From the next cycle, `mem_strobe` and `mem_cycle` are 1, `mem_write` equals the request's `cpu_we`, and `cpu_ready` is 0.
- R3: `mem_strobe` and `mem_cycle` are equal in every cycle.
- R4: While a request is outstanding and `mem_ack` is 0, `mem_strobe`, `mem_write`, `mem_addr`, `mem_wdata` and `mem_bmask` hold their values, and `cpu_ready` stays 0.
- R5: The cycle after `mem_ack` is seen with `mem_strobe` at 1, `mem_strobe` and `mem_cycle` are 0 and `cpu_ready` is 1. `mem_ack` has no effect while no request is outstanding.
- R6: On a read, byte lane L = physical address bits [1:0] of `mem_rdata` is captured at the acknowledge edge. Lane L occupies bits [8L+7:8L]. The captured byte appears on `cpu_rdata` when `cpu_ready` returns to 1. `cpu_rdata` then holds until the next read completes and is not changed by writes.
- R7: On a write, `mem_wdata` carries the CPU byte copied into all four lanes, and `mem_bmask` has exactly bit L set, where L = physical address bits [1:0]. On a read, `mem_bmask` is 0.
- R8: `mem_addr` equals bits [22:2] of the physical byte address {bank[6:0], cpu_addr[15:0]}.
- R9: A CPU write to address 16'hFF90 while `cpu_ready` is 1 loads `cpu_wdata[6:0]` into the bank register. It starts no controller request: `mem_strobe` stays 0 and `cpu_ready` stays 1.
- R10: `cpu_req` has no effect while a request is outstanding. `mem_addr` and `mem_write` keep the values of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned by the last completed read |
| cpu_ready | output | 1 | 1 = idle, able to accept a request; 0 = CPU stalled |
| mem_write | output | 1 | Controller direction, 1 = write |
| mem_strobe | output | 1 | Controller request line |
| mem_cycle | output | 1 | Controller request line, same timing as mem_strobe |
| mem_addr | output | 21 | Controller word address |
| mem_wdata | output | 32 | Controller write word |
| mem_bmask | output | 4 | Controller byte-lane enables |
| mem_rdata | input | 32 | Controller read word |
| mem_ack | input | 1 | Controller acknowledge |

## Verification
A wrong state in the handshake shows within one cycle of the acknowledge. If the request lines stay high, or `cpu_ready` stays low, after `mem_ack`, the check on the next sampled cycle catches it. If `mem_strobe` and `mem_cycle` ever differ, that is visible on the same cycle. A bank register that is not loaded or not reset stays hidden until the next access, and then shows as a wrong `mem_addr` in the first request cycle. A wrong lane choice shows as a wrong `mem_bmask` while the write is outstanding. On a read it shows as a wrong `cpu_rdata` the cycle `cpu_ready` returns to 1.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  parameter int CPU_AW = 16;
  parameter int CPU_DW = 8;
  parameter int MEM_DW = 32;
  parameter int BANK_W = 7;

  localparam int PHYS_AW = CPU_AW + BANK_W;
  localparam int LANES   = MEM_DW / CPU_DW;
  localparam int LANE_W  = $clog2(LANES);
  localparam int WORD_AW = PHYS_AW - LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } acc_state_t;

  function automatic logic [PHYS_AW-1:0] phys_of(input logic [BANK_W-1:0] bank,
                                                input logic [CPU_AW-1:0] addr);
    return {bank, addr};
  endfunction

  function automatic logic [WORD_AW-1:0] word_of(input logic [PHYS_AW-1:0] phys);
    return phys[PHYS_AW-1:LANE_W];
  endfunction

  function automatic logic [LANE_W-1:0] lane_of(input logic [PHYS_AW-1:0] phys);
    return phys[LANE_W-1:0];
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [LANE_W-1:0] lane);
    logic [LANES-1:0] m;
    m = '0;
    m[lane] = 1'b1;
    return m;
  endfunction

  function automatic logic [MEM_DW-1:0] spread(input logic [CPU_DW-1:0] b);
    return {LANES{b}};
  endfunction

  function automatic logic [CPU_DW-1:0] pick(input logic [MEM_DW-1:0] w,
                                             input logic [LANE_W-1:0] lane);
    return w[lane*CPU_DW +: CPU_DW];
  endfunction
endpackage

// File: rtl/bridge_bank_reg.sv
module bridge_bank_reg
  import bridge_pkg::*;
#(
  parameter logic [CPU_AW-1:0] IO_ADDR = 16'hFF90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              idle,
  output logic [BANK_W-1:0] bank,
  output logic              bank_wr_evt
);
  assign bank_wr_evt = idle && cpu_req && cpu_we && (cpu_addr == IO_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)           bank <= '0;
    else if (bank_wr_evt) bank <= bank_in;
  end
endmodule

// File: rtl/bridge_access_fsm.sv
module bridge_access_fsm
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_we,
  input  logic       mem_ack,
  output acc_state_t state,
  output logic       idle,
  output logic       done_rd,
  output logic       mem_write,
  output logic       mem_strobe,
  output logic       mem_cycle
);
  acc_state_t nxt;
  logic       done_evt;

  assign idle     = (state == ST_IDLE);
  assign done_evt = !idle && mem_ack;
  assign done_rd  = done_evt && (state == ST_RD);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = start_we ? ST_WR : ST_RD;
      ST_RD,
      ST_WR:   if (mem_ack) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mem_write  <= 1'b0;
      mem_strobe <= 1'b0;
      mem_cycle  <= 1'b0;
    end else begin
      state <= nxt;
      if (idle && start) begin
        mem_write  <= start_we;
        mem_strobe <= 1'b1;
        mem_cycle  <= 1'b1;
      end else if (done_evt) begin
        mem_write  <= 1'b0;
        mem_strobe <= 1'b0;
        mem_cycle  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bridge_lane_path.sv
module bridge_lane_path
  import bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               load_we,
  input  logic [PHYS_AW-1:0] phys,
  input  logic [CPU_DW-1:0]  wdata,
  input  logic               done_rd,
  input  logic [MEM_DW-1:0]  mem_rdata,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0]  mem_wdata,
  output logic [LANES-1:0]   mem_bmask,
  output logic [CPU_DW-1:0]  cpu_rdata
);
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_bmask <= '0;
      lane_q    <= '0;
    end else if (load) begin
      mem_addr  <= word_of(phys);
      lane_q    <= lane_of(phys);
      mem_wdata <= load_we ? spread(wdata) : '0;
      mem_bmask <= load_we ? lane_mask(lane_of(phys)) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cpu_rdata <= '0;
    else if (done_rd) cpu_rdata <= pick(mem_rdata, lane_q);
  end
endmodule

// File: rtl/cpu_dram_bridge.sv
module cpu_dram_bridge
  import bridge_pkg::*;
#(
  parameter logic [CPU_AW-1:0] BANK_IO_ADDR = 16'hFF90
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [CPU_DW-1:0]  cpu_wdata,
  output logic [CPU_DW-1:0]  cpu_rdata,
  output logic               cpu_ready,
  output logic               mem_write,
  output logic               mem_strobe,
  output logic               mem_cycle,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0]  mem_wdata,
  output logic [LANES-1:0]   mem_bmask,
  input  logic [MEM_DW-1:0]  mem_rdata,
  input  logic               mem_ack
);
  logic               idle;
  logic               done_rd;
  logic               bank_wr_evt;
  logic               accept_evt;
  logic [BANK_W-1:0]  bank;
  logic [PHYS_AW-1:0] phys;
  acc_state_t         state;

  assign accept_evt = idle && cpu_req && !bank_wr_evt;
  assign phys       = phys_of(bank, cpu_addr);
  assign cpu_ready  = idle;

  bridge_bank_reg #(.IO_ADDR(BANK_IO_ADDR)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .bank_in    (cpu_wdata[BANK_W-1:0]),
    .idle       (idle),
    .bank       (bank),
    .bank_wr_evt(bank_wr_evt)
  );

  bridge_access_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_evt),
    .start_we  (cpu_we),
    .mem_ack   (mem_ack),
    .state     (state),
    .idle      (idle),
    .done_rd   (done_rd),
    .mem_write (mem_write),
    .mem_strobe(mem_strobe),
    .mem_cycle (mem_cycle)
  );

  bridge_lane_path u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .load_we  (cpu_we),
    .phys     (phys),
    .wdata    (cpu_wdata),
    .done_rd  (done_rd),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_bmask(mem_bmask),
    .cpu_rdata(cpu_rdata)
  );
endmodule

// File: rtl/cpu_dram_bridge_chk.sv
module cpu_dram_bridge_chk
  import bridge_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_we,
  input logic               cpu_ready,
  input logic               mem_write,
  input logic               mem_strobe,
  input logic               mem_cycle,
  input logic [WORD_AW-1:0] mem_addr,
  input logic [LANES-1:0]   mem_bmask,
  input logic               mem_ack,
  input logic               accept_evt,
  input logic               bank_wr_evt
);
  AST_STB_CYC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe == mem_cycle); // R3
  AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> mem_strobe && !cpu_ready && (mem_write == $past(cpu_we))); // R2
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && !mem_ack) |=> mem_strobe && $stable(mem_addr) && $stable(mem_write) && $stable(mem_bmask)); // R4
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> !cpu_ready); // R4
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && mem_ack) |=> !mem_strobe && cpu_ready); // R5
  AST_WR_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && mem_write) |-> $countones(mem_bmask) == 1); // R7
  AST_RD_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && !mem_write) |-> mem_bmask == '0); // R7
  AST_BANK_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_evt |=> !mem_strobe && cpu_ready); // R9
endmodule

bind cpu_dram_bridge cpu_dram_bridge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_we     (cpu_we),
  .cpu_ready  (cpu_ready),
  .mem_write  (mem_write),
  .mem_strobe (mem_strobe),
  .mem_cycle  (mem_cycle),
  .mem_addr   (mem_addr),
  .mem_bmask  (mem_bmask),
  .mem_ack    (mem_ack),
  .accept_evt (accept_evt),
  .bank_wr_evt(bank_wr_evt)
);

// File: tb/cpu_dram_bridge_tb.sv
module cpu_dram_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic        mem_write, mem_strobe, mem_cycle;
  logic [20:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_bmask;
  logic [31:0] mem_rdata;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [6:0] bank_m = '0;
  logic [7:0] last_rd = '0;

  typedef struct { bit is_rd; logic [7:0] val; } exp_t;
  exp_t sb_q[$];

  logic [31:0] wmem [int];
  logic [7:0]  shadow [int];

  always #2 clk = ~clk;

  cpu_dram_bridge u_dut (.*);

  function automatic logic [31:0] seed_word(input logic [20:0] w);
    return {w[7:0] ^ 8'h5A, w[15:8], 3'b101, w[20:16], ~w[7:0]};
  endfunction

  function automatic logic [31:0] get_word(input logic [20:0] w);
    return wmem.exists(int'(w)) ? wmem[int'(w)] : seed_word(w);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [22:0] p);
    logic [31:0] sw;
    if (shadow.exists(int'(p))) return shadow[int'(p)];
    sw = seed_word(p[22:2]);
    case (p[1:0])
      2'd0: return sw[7:0];
      2'd1: return sw[15:8];
      2'd2: return sw[23:16];
      default: return sw[31:24];
    endcase
  endfunction

  assign mem_rdata = get_word(mem_addr);

  // controller model: acknowledge after a rotating delay
  logic [1:0] dly = 2'd0;
  logic [1:0] cnt = 2'd0;
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt     <= 2'd0;
      dly     <= dly + 2'd1;
    end else if (mem_strobe) begin
      if (cnt == dly) begin
        mem_ack <= 1'b1;
        if (mem_write) begin
          logic [31:0] w;
          w = get_word(mem_addr);
          for (int i = 0; i < 4; i++)
            if (mem_bmask[i]) w[i*8 +: 8] = mem_wdata[i*8 +: 8];
          wmem[int'(mem_addr)] = w;
        end
      end else cnt <= cnt + 2'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare results as each access completes
  logic prev_rdy = 1'b1;
  always @(negedge clk) begin
    if (rst_n && cpu_ready && !prev_rdy) begin
      if (sb_q.size() == 0) chk("R5 unexpected completion", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.is_rd) begin
          chk("R6 read lane", {24'd0, cpu_rdata}, {24'd0, e.val});
          last_rd = e.val;
        end else chk("R6 rdata held over write", {24'd0, cpu_rdata}, {24'd0, last_rd});
      end
      chk("R5 request released", {31'd0, mem_strobe | mem_cycle}, 32'd0);
    end
    if (rst_n) chk("R3 strobe equals cycle", {31'd0, mem_strobe}, {31'd0, mem_cycle});
    prev_rdy = cpu_ready;
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d, input bit poke);
    logic [22:0] p;
    exp_t e;
    p = {bank_m, a};
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R2 strobe raised", {31'd0, mem_strobe}, 32'd1);
    chk("R2 write bit", {31'd0, mem_write}, {31'd0, we});
    chk("R2 cpu stalled", {31'd0, cpu_ready}, 32'd0);
    chk("R8 word address", {11'd0, mem_addr}, {11'd0, p[22:2]});
    if (we) begin
      chk("R7 lane mask", {28'd0, mem_bmask}, {28'd0, 4'b0001 << p[1:0]});
      chk("R7 replicated data", mem_wdata, {4{d}});
      shadow[int'(p)] = d;
    end else chk("R7 read mask zero", {28'd0, mem_bmask}, 32'd0);
    e.is_rd = !we;
    e.val   = exp_byte(p);
    sb_q.push_back(e);
    if (poke && !mem_ack) begin
      cpu_req = 1'b1; cpu_we = !we; cpu_addr = ~a; cpu_wdata = ~d;
      @(negedge clk);
      cpu_req = 1'b0;
      chk("R10 busy request ignored addr", {11'd0, mem_addr}, {11'd0, p[22:2]});
      chk("R10 busy request ignored dir", {31'd0, mem_write}, {31'd0, we});
    end
    while (!cpu_ready) begin
      if (!mem_ack) chk("R4 held while waiting", {11'd0, mem_addr}, {11'd0, p[22:2]});
      @(negedge clk);
    end
  endtask

  task automatic set_bank(input logic [7:0] v);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'hFF90; cpu_wdata = v;
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R9 no request for bank write", {31'd0, mem_strobe}, 32'd0);
    chk("R9 cpu stays ready", {31'd0, cpu_ready}, 32'd1);
    bank_m = v[6:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", {31'd0, cpu_ready}, 32'd1);
    chk("R1 strobe low", {31'd0, mem_strobe}, 32'd0);
    chk("R1 cycle low", {31'd0, mem_cycle}, 32'd0);
    chk("R1 write low", {31'd0, mem_write}, 32'd0);
    rst_n = 1'b1;
    // R1: bank 0 after reset, seen on first address
    access(1'b0, 16'h1235, 8'h00, 1'b0);
    access(1'b1, 16'h1236, 8'hC3, 1'b1);
    access(1'b0, 16'h1236, 8'h00, 1'b0);
    access(1'b0, 16'h1237, 8'h00, 1'b1);
    // R5: acknowledge while idle has no effect
    @(negedge clk); mem_ack = 1'b1; @(negedge clk); mem_ack = 1'b0;
    chk("R5 ack while idle", {31'd0, mem_strobe}, 32'd0);
    set_bank(8'hA5);
    access(1'b1, 16'h0001, 8'h3C, 1'b0);
    access(1'b0, 16'h0001, 8'h00, 1'b1);
    access(1'b0, 16'h0000, 8'h00, 1'b0);
    access(1'b0, 16'hFF90, 8'h00, 1'b0);
    set_bank(8'h7F);
    for (int i = 0; i < 8; i++) access(1'b1, 16'hFFF8 + 16'(i), 8'(8'h10 + i), i[0]);
    for (int i = 0; i < 8; i++) access(1'b0, 16'hFFF8 + 16'(i), 8'h00, i[1]);
    set_bank(8'h00);
    access(1'b0, 16'h1236, 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6 queue drained", sb_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule